// File: doc/BRIEF.md
# NOR Flash Command Interpreter

This block is the device-side command decoder of a behavioural NOR flash model with 16-bit words. The host writes command bytes on the low data byte during bus write cycles. The decoder turns them into read-mode changes and into two-cycle operations: word program, block erase, block lock and unlock, and protection-register program. An 8-bit status word reports readiness, errors and suspension. The busy period of the internal write engine is a down-counter whose length is set by a parameter.

The storage is a small register file split into equal blocks. A block is selected by the upper `BLK_W` address bits. Each block has a lock bit. There is also a protection register of `2**PR_AW` words. A program or erase that is running can be suspended and resumed, and neither command changes what reads return. Errors latch until the host clears them.

There are two resets. `pwrRstN` is the power-on reset: it sets every array and protection word to 0xFFFF and unlocks all blocks. `rstN` is the device reset: it returns the decoder and the status to their idle state and leaves the storage and the lock bits untouched.

Top module: `norcui_top`

## Requirements
- R1: After reset the block is in array-read mode, erased words read 0xFFFF, and the status word reads 0x0080.
- R2: Command 0xFF selects array reads, 0x70 selects status reads and 0x90 selects protection-register reads. Status appears on bits 7:0 with bits 15:8 at zero. Status bit 7 = ready, 6 = erase suspended, 5 = erase error, 4 = program error, 3 = always 0, 2 = program suspended, 1 = lock error, 0 = always 0. In protection-register mode, the low `PR_AW` address bits select the word.
- R3: Command 0x20 followed by 0xD0 erases the block addressed in the second cycle to 0xFFFF. Status bit 7 reads 0 for exactly `BUSY_CYC` cycles after the confirm edge. Other blocks are unchanged.
- R4: Command 0x40 followed by an address/data cycle ANDs the data into that word after a busy period of `BUSY_CYC` cycles. Every two-cycle setup command switches reads to status.
- R5: If 0xD0 does not follow 0x20, or if neither 0x01 nor 0xD0 follows 0x60, the status reads 0x00B0 at once and the array is unchanged.
- R6: Status bits 5, 4 and 1 stay set through later operations until command 0x50 clears them. Status then reads 0x0080.
- R7: A program or erase aimed at a locked block starts no busy period, leaves the array unchanged, and sets status 0x0092 for a program or 0x00A2 for an erase.
- R8: Command 0x60 followed by 0x01 locks the addressed block, and 0x60 followed by 0xD0 unlocks it. Lock bits survive `rstN` and are cleared only by `pwrRstN`.
- R9: Command 0xC0 followed by an address/data cycle ANDs the data into the protection-register word, with the same busy period as a program.
- R10: Command 0xB0 during a busy period freezes it and sets status 0x00C0 for an erase or 0x0084 for a program. The read mode is kept. While suspended, only 0xFF, 0x70, 0x90, 0x50 and 0xD0 are accepted.
- R11: Command 0xD0 while suspended resumes the operation without changing the read mode. The suspend edge does not count, so when the suspend lands m edges after the confirm edge, ready returns `BUSY_CYC`−m+1 cycles after the resume edge.
- R12: `rstN` aborts any sequence or busy period, clears the status to 0x0080 and selects array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrRstN | input | 1 | Power-on reset, active low, clears storage and locks |
| rstN | input | 1 | Device reset, active low, clears decoder and status |
| wrEn | input | 1 | Bus write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W | Word address for writes and reads |
| wrData | input | 16 | Write data; command code on bits 7:0 |
| rdData | output | 16 | Read data for the current mode and address (combinational) |

## Verification
Commands take effect at the clock edge that samples `wrEn`. Read data is combinational from registered state, so the bench drives each write at a falling edge and reads one time unit after the next falling edge. Mode changes, sequence errors and lock errors are therefore visible in the first sample after the command. Busy periods are measured by polling status bit 7 once per falling edge after the confirm edge. The bench compares that count with `BUSY_CYC`, or with `BUSY_CYC`−m+1 after a resume. Array results are read only after ready has returned.

// File: rtl/norcui_pkg.sv
package norcui_pkg;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_PROT    = 8'h90;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_LOCKSET = 8'h60;
  localparam logic [7:0] CMD_PRPROG  = 8'hC0;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_LOCK    = 8'h01;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;

  typedef enum logic [1:0] {MODE_ARRAY, MODE_STATUS, MODE_PROT} readMode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_BUSY} ctrlState_e;
  typedef enum logic [1:0] {SK_ERASE, SK_PROG, SK_LOCK, SK_PR} setupKind_e;

  typedef struct packed {
    logic doProg;
    logic doErase;
    logic doPrProg;
    logic doLock;
    logic doUnlock;
    logic errSeq;
    logic errLockProg;
    logic errLockErase;
    logic clrStat;
  } dpStrobe_t;

endpackage

// File: rtl/norcui_ctrl.sv
module norcui_ctrl
  import norcui_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              blkLocked,
  output dpStrobe_t         stb,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [DATA_W-1:0] opData,
  output readMode_e         mode,
  output logic              ready,
  output logic              ersSusp,
  output logic              prgSusp
);

  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  ctrlState_e        state, stateN;
  setupKind_e        kind, kindN;
  readMode_e         modeN;
  logic              suspended, suspN;
  logic              busyErase, busyEraseN;
  logic              busyPr, busyPrN;
  logic [CNT_W-1:0]  cnt, cntN;
  logic [ADDR_W-1:0] opAddr, opAddrN;
  logic [DATA_W-1:0] opDataN;
  logic [7:0]        cmd;

  assign cmd = wrData[7:0];

  always_comb begin
    stb = '0;
    stateN = state; kindN = kind; modeN = mode; suspN = suspended;
    cntN = cnt; opAddrN = opAddr; opDataN = opData;
    busyEraseN = busyErase; busyPrN = busyPr;
    case (state)
      ST_IDLE: if (wrEn) begin
        case (cmd)
          CMD_ARRAY:   modeN = MODE_ARRAY;
          CMD_STATUS:  modeN = MODE_STATUS;
          CMD_PROT:    modeN = MODE_PROT;
          CMD_CLEAR:   stb.clrStat = 1'b1;
          CMD_ERASE:   begin stateN = ST_SETUP; kindN = SK_ERASE; modeN = MODE_STATUS; end
          CMD_PROG:    begin stateN = ST_SETUP; kindN = SK_PROG;  modeN = MODE_STATUS; end
          CMD_LOCKSET: begin stateN = ST_SETUP; kindN = SK_LOCK;  modeN = MODE_STATUS; end
          CMD_PRPROG:  begin stateN = ST_SETUP; kindN = SK_PR;    modeN = MODE_STATUS; end
          default: ;
        endcase
      end
      ST_SETUP: if (wrEn) begin
        stateN = ST_IDLE;
        case (kind)
          SK_ERASE:
            if (cmd != CMD_CONFIRM) stb.errSeq = 1'b1;
            else if (blkLocked) stb.errLockErase = 1'b1;
            else begin
              stateN = ST_BUSY; cntN = CNT_W'(BUSY_CYC);
              busyEraseN = 1'b1; busyPrN = 1'b0; opAddrN = addr;
            end
          SK_PROG:
            if (blkLocked) stb.errLockProg = 1'b1;
            else begin
              stateN = ST_BUSY; cntN = CNT_W'(BUSY_CYC);
              busyEraseN = 1'b0; busyPrN = 1'b0; opAddrN = addr; opDataN = wrData;
            end
          SK_PR: begin
            stateN = ST_BUSY; cntN = CNT_W'(BUSY_CYC);
            busyEraseN = 1'b0; busyPrN = 1'b1; opAddrN = addr; opDataN = wrData;
          end
          default:
            if (cmd == CMD_LOCK) stb.doLock = 1'b1;
            else if (cmd == CMD_CONFIRM) stb.doUnlock = 1'b1;
            else stb.errSeq = 1'b1;
        endcase
      end
      ST_BUSY:
        if (!suspended) begin
          if (cnt == CNT_W'(1)) begin
            stateN = ST_IDLE;
            if (busyErase) stb.doErase = 1'b1;
            else if (busyPr) stb.doPrProg = 1'b1;
            else stb.doProg = 1'b1;
          end else if (wrEn && cmd == CMD_SUSPEND) begin
            suspN = 1'b1;
          end else begin
            cntN = cnt - CNT_W'(1);
          end
        end else if (wrEn) begin
          case (cmd)
            CMD_ARRAY:   modeN = MODE_ARRAY;
            CMD_STATUS:  modeN = MODE_STATUS;
            CMD_PROT:    modeN = MODE_PROT;
            CMD_CLEAR:   stb.clrStat = 1'b1;
            CMD_CONFIRM: suspN = 1'b0;
            default: ;
          endcase
        end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; kind <= SK_ERASE; mode <= MODE_ARRAY;
      suspended <= 1'b0; busyErase <= 1'b0; busyPr <= 1'b0;
      cnt <= '0; opAddr <= '0; opData <= '0;
    end else begin
      state <= stateN; kind <= kindN; mode <= modeN;
      suspended <= suspN; busyErase <= busyEraseN; busyPr <= busyPrN;
      cnt <= cntN; opAddr <= opAddrN; opData <= opDataN;
    end
  end

  assign tgtAddr = (state == ST_BUSY) ? opAddr : addr;
  assign ready   = !(state == ST_BUSY && !suspended);
  assign ersSusp = suspended && busyErase;
  assign prgSusp = suspended && !busyErase;

  // R3
  erase_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP && kind == SK_ERASE && wrEn && cmd == CMD_CONFIRM && !blkLocked)
    |=> (!ready && cnt == CNT_W'(BUSY_CYC)));

  // R5
  seq_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP && kind == SK_ERASE && wrEn && cmd != CMD_CONFIRM)
    |=> (state == ST_IDLE && ready));

  // R10
  susp_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (suspended && !(wrEn && cmd == CMD_CONFIRM)) |=> ($stable(cnt) && ready));

  // R10
  susp_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && !suspended && wrEn && cmd == CMD_SUSPEND) |=> $stable(mode));

endmodule

// File: rtl/norcui_dpath.sv
module norcui_dpath
  import norcui_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BLK_W  = 2,
  parameter int PR_AW  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              pwrRstN,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  readMode_e         mode,
  input  logic              ready,
  input  logic              ersSusp,
  input  logic              prgSusp,
  output logic              blkLocked,
  output logic [DATA_W-1:0] rdData
);

  localparam int WORDS  = 1 << ADDR_W;
  localparam int BLOCKS = 1 << BLK_W;
  localparam int PR_N   = 1 << PR_AW;
  localparam int OFF_W  = ADDR_W - BLK_W;

  logic [DATA_W-1:0] arr [WORDS];
  logic [DATA_W-1:0] prMem [PR_N];
  logic [BLOCKS-1:0] lockBits;
  logic [BLK_W-1:0]  tgtBlk;
  logic              eraseErr, progErr, lockErr;
  logic [7:0]        status;

  assign tgtBlk    = tgtAddr[ADDR_W-1 -: BLK_W];
  assign blkLocked = lockBits[tgtBlk];

  always_ff @(posedge clk or negedge pwrRstN) begin
    if (!pwrRstN) begin
      for (int w = 0; w < WORDS; w++) arr[w] <= '1;
      for (int p = 0; p < PR_N; p++) prMem[p] <= '1;
      lockBits <= '0;
    end else begin
      if (stb.doProg) arr[tgtAddr] <= arr[tgtAddr] & opData;
      if (stb.doErase)
        for (int w = 0; w < WORDS; w++)
          if ((w >> OFF_W) == int'(tgtBlk)) arr[w] <= '1;
      if (stb.doPrProg) prMem[tgtAddr[PR_AW-1:0]] <= prMem[tgtAddr[PR_AW-1:0]] & opData;
      if (stb.doLock)   lockBits[tgtBlk] <= 1'b1;
      if (stb.doUnlock) lockBits[tgtBlk] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseErr <= 1'b0; progErr <= 1'b0; lockErr <= 1'b0;
    end else if (stb.clrStat) begin
      eraseErr <= 1'b0; progErr <= 1'b0; lockErr <= 1'b0;
    end else begin
      if (stb.errSeq || stb.errLockErase) eraseErr <= 1'b1;
      if (stb.errSeq || stb.errLockProg)  progErr  <= 1'b1;
      if (stb.errLockErase || stb.errLockProg) lockErr <= 1'b1;
    end
  end

  assign status = {ready, ersSusp, eraseErr, progErr, 1'b0, prgSusp, lockErr, 1'b0};

  always_comb begin
    case (mode)
      MODE_STATUS: rdData = {{(DATA_W-8){1'b0}}, status};
      MODE_PROT:   rdData = prMem[rdAddr[PR_AW-1:0]];
      default:     rdData = arr[rdAddr];
    endcase
  end

  // R7
  lock_guard_chk: assert property (@(posedge clk) disable iff (!rstN || !pwrRstN)
    (stb.doProg || stb.doErase) |-> !lockBits[tgtBlk]);

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clrStat && (eraseErr || progErr || lockErr))
    |=> (({eraseErr, progErr, lockErr} & $past({eraseErr, progErr, lockErr}))
         == $past({eraseErr, progErr, lockErr})));

  // R8
  lock_keep_chk: assert property (@(posedge clk) disable iff (!pwrRstN)
    !stb.doUnlock |=> ((lockBits & $past(lockBits)) == $past(lockBits)));

endmodule

// File: rtl/norcui_top.sv
module norcui_top
  import norcui_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int BLK_W    = 2,
  parameter int PR_AW    = 2,
  parameter int BUSY_CYC = 8
) (
  input  logic              clk,
  input  logic              pwrRstN,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData
);

  localparam int DATA_W = 16;

  dpStrobe_t         stb;
  logic [ADDR_W-1:0] tgtAddr;
  logic [DATA_W-1:0] opData;
  readMode_e         mode;
  logic              ready, ersSusp, prgSusp, blkLocked;

  norcui_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .blkLocked(blkLocked), .stb(stb), .tgtAddr(tgtAddr), .opData(opData),
    .mode(mode), .ready(ready), .ersSusp(ersSusp), .prgSusp(prgSusp));

  norcui_dpath #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PR_AW(PR_AW), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .pwrRstN(pwrRstN), .rstN(rstN), .stb(stb), .tgtAddr(tgtAddr),
    .opData(opData), .rdAddr(addr), .mode(mode), .ready(ready),
    .ersSusp(ersSusp), .prgSusp(prgSusp), .blkLocked(blkLocked), .rdData(rdData));

endmodule

// File: tb/norcui_top_tb_top.sv
module norcui_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 8;

  logic        clk = 1'b0;
  logic        pwrRstN = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  norcui_top #(.ADDR_W(6), .BLK_W(2), .PR_AW(2), .BUSY_CYC(BUSY_CYC)) dut_i (
    .clk(clk), .pwrRstN(pwrRstN), .rstN(rstN), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData));

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitReady(output int n);
    logic [15:0] v;
    n = 0;
    rd(0, v);
    while (!v[7] && n < 1000) begin
      @(negedge clk);
      n++;
      rd(0, v);
    end
  endtask

  task automatic devReset();
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic progWord(input logic [5:0] a, input logic [15:0] d);
    int n;
    wr(a, 16'h0040);
    wr(a, d);
    waitReady(n);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    repeat (3) @(negedge clk);
    pwrRstN = 1'b1; rstN = 1'b1;
    rd(3, v);  check("R1 array read after reset", v, 16'hFFFF);
    wr(0, 16'h0070);
    rd(0, v);  check("R1 status after reset", v, 16'h0080);
  endtask

  task automatic t_modes();
    logic [15:0] v;
    wr(0, 16'h00FF); rd(3, v); check("R2 array mode", v, 16'hFFFF);
    wr(0, 16'h0090); rd(1, v); check("R2 protection mode", v, 16'hFFFF);
    wr(0, 16'h0070); rd(9, v); check("R2 status mode upper zero", v, 16'h0080);
  endtask

  task automatic t_program();
    logic [15:0] v; int n;
    wr(5, 16'h0040);
    rd(0, v); check("R4 setup selects status", v, 16'h0080);
    wr(5, 16'h1234);
    waitReady(n); check("R4 busy cycles", 16'(n), 16'(BUSY_CYC));
    wr(0, 16'h00FF); rd(5, v); check("R4 word programmed", v, 16'h1234);
    wr(5, 16'h0040); wr(5, 16'hFF0F); waitReady(n);
    wr(0, 16'h00FF); rd(5, v); check("R4 AND semantics", v, 16'h1204);
  endtask

  task automatic t_erase();
    logic [15:0] v; int n;
    progWord(20, 16'h00AA);
    wr(5, 16'h0020); wr(5, 16'h00D0);
    waitReady(n); check("R3 erase busy cycles", 16'(n), 16'(BUSY_CYC));
    wr(0, 16'h00FF);
    rd(5, v);  check("R3 block erased", v, 16'hFFFF);
    rd(20, v); check("R3 other block kept", v, 16'h00AA);
  endtask

  task automatic t_seqerr();
    logic [15:0] v;
    wr(20, 16'h0020); wr(20, 16'h0033);
    rd(0, v); check("R5 erase sequence error", v, 16'h00B0);
    wr(0, 16'h00FF); rd(20, v); check("R5 array unchanged", v, 16'h00AA);
    progWord(21, 16'h0F0F);
    rd(0, v); check("R6 error bits sticky", v, 16'h00B0);
    wr(0, 16'h0050); rd(0, v); check("R6 clear status", v, 16'h0080);
    wr(0, 16'h0060); wr(0, 16'h0077);
    rd(0, v); check("R5 lock sequence error", v, 16'h00B0);
    wr(0, 16'h0050);
  endtask

  task automatic t_lock();
    logic [15:0] v; int n;
    wr(40, 16'h0060); wr(40, 16'h0001);
    wr(41, 16'h0040); wr(41, 16'h0000);
    rd(0, v); check("R7 locked program status", v, 16'h0092);
    wr(0, 16'h0050);
    wr(40, 16'h0020); wr(40, 16'h00D0);
    rd(0, v); check("R7 locked erase status", v, 16'h00A2);
    wr(0, 16'h00FF); rd(41, v); check("R7 array unchanged", v, 16'hFFFF);
    devReset();
    rd(41, v); check("R12 array mode after reset", v, 16'hFFFF);
    wr(0, 16'h0070); rd(0, v); check("R12 status cleared", v, 16'h0080);
    wr(41, 16'h0040); wr(41, 16'h0000);
    rd(0, v); check("R8 lock survives reset", v, 16'h0092);
    wr(0, 16'h0050);
    wr(40, 16'h0060); wr(40, 16'h00D0);
    wr(41, 16'h0040); wr(41, 16'h5555);
    waitReady(n); check("R8 unlocked program busy", 16'(n), 16'(BUSY_CYC));
    wr(0, 16'h00FF); rd(41, v); check("R8 unlocked program", v, 16'h5555);
  endtask

  task automatic t_abort();
    logic [15:0] v;
    wr(48, 16'h0020); wr(48, 16'h00D0);
    @(negedge clk);
    rd(0, v); check("R12 busy before reset", v, 16'h0000);
    devReset();
    wr(0, 16'h0070); rd(0, v); check("R12 abort to ready", v, 16'h0080);
  endtask

  task automatic t_pr();
    logic [15:0] v; int n;
    wr(1, 16'h00C0); wr(1, 16'hA5A5);
    waitReady(n); check("R9 busy cycles", 16'(n), 16'(BUSY_CYC));
    wr(0, 16'h0090);
    rd(1, v); check("R9 protection word", v, 16'hA5A5);
    rd(0, v); check("R9 other protection word", v, 16'hFFFF);
    wr(0, 16'h0070);
  endtask

  task automatic t_susp_prog();
    logic [15:0] v; int n;
    wr(60, 16'h0040); wr(60, 16'h00F0);
    repeat (2) @(negedge clk);
    wr(0, 16'h00B0);
    rd(0, v); check("R10 program suspended status", v, 16'h0084);
    repeat (10) @(negedge clk);
    rd(0, v); check("R10 suspension holds", v, 16'h0084);
    wr(0, 16'h00FF); rd(60, v); check("R10 array untouched", v, 16'hFFFF);
    wr(0, 16'h0070);
    wr(0, 16'h00D0);
    rd(0, v); check("R11 busy after resume", v, 16'h0000);
    waitReady(n); check("R11 remaining cycles", 16'(n), 16'(BUSY_CYC - 2));
    wr(0, 16'h00FF); rd(60, v); check("R11 program completes", v, 16'h00F0);
  endtask

  task automatic t_susp_erase();
    logic [15:0] v;
    progWord(50, 16'h0F0F);
    wr(50, 16'h0020); wr(50, 16'h00D0);
    @(negedge clk);
    wr(0, 16'h00B0);
    rd(0, v); check("R10 erase suspended status", v, 16'h00C0);
    wr(0, 16'h00FF); rd(50, v); check("R10 array read while suspended", v, 16'h0F0F);
    wr(0, 16'h00D0);
    rd(50, v); check("R11 resume keeps array mode", v, 16'h0F0F);
    repeat (BUSY_CYC + 2) @(negedge clk);
    rd(50, v); check("R11 erase completes", v, 16'hFFFF);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_modes();
    t_program();
    t_erase();
    t_seqerr();
    t_lock();
    t_abort();
    t_pr();
    t_susp_prog();
    t_susp_erase();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule